// File: doc/BRIEF.md
# Converter power-mode pulse decoder

This block is the device-side control logic of a serial analog-to-digital converter that has no configuration registers. The host picks a low-power state purely by toggling the conversion-start line while the serial clock is parked low. The block watches the serial clock, the conversion-start line and an active-low shutdown line. All three are asynchronous to the block's own system clock. From them it tracks one of four power states and drives the power enables for the comparator and the reference.

Two conversion-start pulses with the serial clock held low put the converter into a light low-power state. In that state the comparator is unpowered and the reference stays up. Four such pulses put it into a deep state with both unpowered. Any rising serial-clock edge wakes it. Pulling the shutdown line low forces a full power-off state, whatever else is going on. A reference-ready flag is low while the reference is unpowered. It rises only after a configurable number of system clock cycles, which stands in for the reference settling again.

Top module: `conv_pwr_decoder`

## Requirements
- R1: After reset, state_o is ACTIVE (2'b00), cmp_en_o and ref_en_o are 1, and ref_rdy_o is 0.
- R2: With sclk_i held low, the second falling edge of conv_i moves state_o from ACTIVE to NAP (2'b01). In NAP, cmp_en_o is 0 and ref_en_o is 1.
- R3: A third falling edge of conv_i with sclk_i still low leaves state_o in NAP.
- R4: A fourth falling edge of conv_i with sclk_i still low moves state_o to SLEEP (2'b10). In SLEEP, cmp_en_o, ref_en_o and ref_rdy_o are all 0.
- R5: A high level on sclk_i clears the pulse count, so pulses separated by a serial-clock pulse never add up to a low-power entry.
- R6: A rising edge of sclk_i in NAP or SLEEP returns state_o to ACTIVE.
- R7: While sd_n_i is low, state_o is SHUTDOWN (2'b11) with both enables 0. This overrides every other input and clears the pulse count.
- R8: When sd_n_i returns high, state_o goes from SHUTDOWN to ACTIVE.
- R9: ref_rdy_o is 0 whenever ref_en_o is 0. After ref_en_o turns on, ref_rdy_o rises exactly REF_SETTLE_CYC clock cycles after state_o changes. It stays 1 through NAP.
- R10: state_o changes on the third rising clk_i edge after a change on sclk_i or sd_n_i. It changes on the fourth rising edge after a qualifying falling edge of conv_i.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Converter serial clock (asynchronous) |
| conv_i | input | 1 | Conversion-start line (asynchronous) |
| sd_n_i | input | 1 | Active-low shutdown request (asynchronous) |
| state_o | output | 2 | Power state: 00 ACTIVE, 01 NAP, 10 SLEEP, 11 SHUTDOWN |
| cmp_en_o | output | 1 | Comparator power enable |
| ref_en_o | output | 1 | Reference power enable |
| ref_rdy_o | output | 1 | Reference settled and usable |

## Verification
A change on sclk_i or sd_n_i is due in state_o on the third clk_i edge: two synchronizer flops, then the state register. A conv_i falling edge goes through one more register, the pulse counter, and is due on the fourth edge. The enables follow the state with no delay. ref_rdy_o rises REF_SETTLE_CYC edges after the state change that powers the reference. Every input is driven on a falling clock edge, and the bench steps a counted number of rising edges before sampling at the next falling edge. At the latency boundaries it samples one edge early to show the old value, then at the due edge to show the new one.

// File: rtl/conv_pwr_pkg.sv
package conv_pwr_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_NAP    = 2'b01,
    PM_SLEEP  = 2'b10,
    PM_SHUT   = 2'b11
  } pm_state_e;
endpackage

// File: rtl/conv_pwr_sync.sv
module conv_pwr_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/conv_pwr_pulse_cnt.sv
module conv_pwr_pulse_cnt #(
  parameter int unsigned MAX_CNT = 4,
  localparam int unsigned CW = $clog2(MAX_CNT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          pulse_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (pulse_i && (cnt_q != CW'(MAX_CNT)));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/conv_pwr_settle.sv
module conv_pwr_settle #(
  parameter int unsigned SETTLE_CYC = 300000,
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_en_i,
  output logic rdy_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !pwr_en_i || !rdy_q;
    cnt_d  = pwr_en_i ? cnt_q + 1'b1 : '0;
    rdy_d  = pwr_en_i && (rdy_q || (cnt_q == CW'(SETTLE_CYC - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_o = rdy_q && pwr_en_i;
endmodule

// File: rtl/conv_pwr_decoder.sv
module conv_pwr_decoder #(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned NAP_PULSES     = 2,
  parameter int unsigned SLEEP_PULSES   = 4,
  parameter int unsigned REF_SETTLE_CYC = 300000,
  localparam int unsigned CW = $clog2(SLEEP_PULSES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       conv_i,
  input  logic       sd_n_i,
  output logic [1:0] state_o,
  output logic       cmp_en_o,
  output logic       ref_en_o,
  output logic       ref_rdy_o
);
  import conv_pwr_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [2:0] in_s;
  logic       sclk_s, conv_s, sd_s;

  conv_pwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_s),
    .d_i   ({sd_n_i, conv_i, sclk_i}),
    .q_o   (in_s)
  );
  assign {sd_s, conv_s, sclk_s} = in_s;

  logic sclk_d, conv_d;
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sclk_d <= 1'b0;
      conv_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      conv_d <= conv_s;
    end
  end

  logic sclk_rise, conv_fall;
  assign sclk_rise = sclk_s && !sclk_d;
  assign conv_fall = conv_d && !conv_s && !sclk_s;

  logic [CW-1:0] pulse_cnt;
  conv_pwr_pulse_cnt #(.MAX_CNT(SLEEP_PULSES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .clr_i  (sclk_s || !sd_s),
    .pulse_i(conv_fall),
    .cnt_o  (pulse_cnt)
  );

  pm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!sd_s) begin
      state_d = PM_SHUT;
    end else begin
      unique case (state_q)
        PM_SHUT:   state_d = PM_ACTIVE;
        PM_ACTIVE: if (!sclk_s) begin
                     if (pulse_cnt >= CW'(SLEEP_PULSES))    state_d = PM_SLEEP;
                     else if (pulse_cnt >= CW'(NAP_PULSES)) state_d = PM_NAP;
                   end
        PM_NAP:    if (sclk_rise) state_d = PM_ACTIVE;
                   else if (pulse_cnt >= CW'(SLEEP_PULSES)) state_d = PM_SLEEP;
        PM_SLEEP:  if (sclk_rise) state_d = PM_ACTIVE;
        default:   state_d = PM_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= PM_ACTIVE;
    else          state_q <= state_d;
  end

  logic cmp_en, ref_en;
  assign cmp_en = (state_q == PM_ACTIVE);
  assign ref_en = (state_q == PM_ACTIVE) || (state_q == PM_NAP);

  conv_pwr_settle #(.SETTLE_CYC(REF_SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .pwr_en_i(ref_en),
    .rdy_o   (ref_rdy_o)
  );

  assign state_o  = state_q;
  assign cmp_en_o = cmp_en;
  assign ref_en_o = ref_en;
endmodule

// File: rtl/conv_pwr_checker.sv
module conv_pwr_checker #(
  parameter int unsigned CW = 3,
  parameter int unsigned SLEEP_PULSES = 4
) (
  input logic          clk_i,
  input logic          rst_n_s,
  input logic [1:0]    state,
  input logic          cmp_en,
  input logic          ref_en,
  input logic          ref_rdy,
  input logic          sd_s,
  input logic          sclk_rise,
  input logic [CW-1:0] cnt
);
  p_shdn_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !sd_s |=> (state == 2'b11) && !cmp_en && !ref_en);

  p_shdn_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (state == 2'b11) && sd_s |=> (state == 2'b00));

  p_nap_power_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (state == 2'b01) |-> !cmp_en && ref_en);

  p_sleep_power_r4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (state == 2'b10) |-> !cmp_en && !ref_en && !ref_rdy);

  p_wake_on_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ((state == 2'b01) || (state == 2'b10)) && sclk_rise && sd_s |=> (state == 2'b00));

  p_ready_needs_ref_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ref_rdy |-> ref_en);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    cnt <= CW'(SLEEP_PULSES));
endmodule

bind conv_pwr_decoder conv_pwr_checker #(.CW(CW), .SLEEP_PULSES(SLEEP_PULSES)) u_chk (
  .clk_i    (clk_i),
  .rst_n_s  (rst_n_s),
  .state    (state_o),
  .cmp_en   (cmp_en_o),
  .ref_en   (ref_en_o),
  .ref_rdy  (ref_rdy_o),
  .sd_s     (sd_s),
  .sclk_rise(sclk_rise),
  .cnt      (pulse_cnt)
);

// File: tb/conv_pwr_decoder_tb.sv
module conv_pwr_decoder_tb;
  localparam int unsigned SETTLE = 20;
  localparam logic [1:0] S_ACT = 2'b00, S_NAP = 2'b01, S_SLP = 2'b10, S_SHUT = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic conv = 1'b0;
  logic sd_n = 1'b1;
  logic [1:0] state;
  logic cmp_en, ref_en, ref_rdy;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  conv_pwr_decoder #(.REF_SETTLE_CYC(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .conv_i(conv), .sd_n_i(sd_n),
    .state_o(state), .cmp_en_o(cmp_en), .ref_en_o(ref_en), .ref_rdy_o(ref_rdy)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic conv_pulse();
    conv = 1'b1; step(3);
    conv = 1'b0; step(4);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; step(3);
    sclk = 1'b0; step(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(3);
    rst_n = 1'b1; step(4);
    chk("R1", state, S_ACT, "state after reset");
    chk("R1", cmp_en, 1, "cmp_en after reset");
    chk("R1", ref_en, 1, "ref_en after reset");
    chk("R1", ref_rdy, 0, "ref_rdy after reset");
    step(SETTLE + 4);
    chk("R9", ref_rdy, 1, "ref_rdy after power-up settle");
  endtask

  task automatic t_nap_entry();
    conv_pulse();
    chk("R2", state, S_ACT, "state after one pulse");
    conv = 1'b1; step(3);
    conv = 1'b0; step(3);
    chk("R10", state, S_ACT, "state one edge before nap due");
    step(1);
    chk("R10", state, S_NAP, "state at nap due edge");
    chk("R2", cmp_en, 0, "cmp_en in nap");
    chk("R2", ref_en, 1, "ref_en in nap");
    chk("R9", ref_rdy, 1, "ref_rdy held in nap");
    conv_pulse();
    chk("R3", state, S_NAP, "state after third pulse");
    sclk = 1'b1; step(2);
    chk("R10", state, S_NAP, "state one edge before wake due");
    step(1);
    chk("R6", state, S_ACT, "state after clock wake from nap");
    chk("R9", ref_rdy, 1, "ref_rdy after nap wake");
    sclk = 1'b0; step(3);
  endtask

  task automatic t_sleep();
    repeat (4) conv_pulse();
    chk("R4", state, S_SLP, "state after four pulses");
    chk("R4", cmp_en, 0, "cmp_en in sleep");
    chk("R4", ref_en, 0, "ref_en in sleep");
    chk("R4", ref_rdy, 0, "ref_rdy in sleep");
    sclk = 1'b1; step(3);
    chk("R6", state, S_ACT, "state after clock wake from sleep");
    step(SETTLE - 1);
    chk("R9", ref_rdy, 0, "ref_rdy one edge before settle");
    step(1);
    chk("R9", ref_rdy, 1, "ref_rdy at settle edge");
    sclk = 1'b0; step(3);
  endtask

  task automatic t_clk_clears();
    conv_pulse();
    sclk_pulse();
    conv_pulse();
    chk("R5", state, S_ACT, "state with pulses split by sclk");
    sclk_pulse();
  endtask

  task automatic t_shutdown();
    sd_n = 1'b0; step(2);
    chk("R10", state, S_ACT, "state one edge before shutdown due");
    step(1);
    chk("R7", state, S_SHUT, "state in shutdown");
    chk("R7", cmp_en, 0, "cmp_en in shutdown");
    chk("R7", ref_en, 0, "ref_en in shutdown");
    chk("R9", ref_rdy, 0, "ref_rdy in shutdown");
    conv_pulse(); conv_pulse(); sclk_pulse();
    chk("R7", state, S_SHUT, "shutdown ignores conv and sclk");
    sd_n = 1'b1; step(3);
    chk("R8", state, S_ACT, "state after shutdown release");
    step(SETTLE - 1);
    chk("R9", ref_rdy, 0, "ref_rdy before settle after shutdown");
    step(1);
    chk("R9", ref_rdy, 1, "ref_rdy at settle after shutdown");
  endtask

  task automatic t_shdn_clears();
    conv_pulse();
    sd_n = 1'b0; step(4);
    sd_n = 1'b1; step(4);
    conv_pulse();
    chk("R7", state, S_ACT, "shutdown cleared pulse count");
    sclk_pulse();
    repeat (4) conv_pulse();
    sd_n = 1'b0; sclk = 1'b1; step(3);
    chk("R7", state, S_SHUT, "shutdown wins over clock wake");
    sclk = 1'b0; sd_n = 1'b1; step(4);
    chk("R8", state, S_ACT, "active after release from sleep path");
  endtask

  initial begin
    step(1);
    t_reset();
    t_nap_entry();
    t_sleep();
    t_clk_clears();
    t_shutdown();
    t_shdn_clears();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule